// File: doc/BRIEF.md
# TLB Maintenance Controller

This block keeps a small fully associative translation cache. Each line holds a mapping for one context. The mapping covers a 4 KiB page, a 256 KiB segment or a 16 MiB region. A table walker writes new lines through a fill port, and each fill goes to the next slot of a round-robin pointer. Software maintains the cache through a control port. A store invalidates lines, and the store address picks the scope of that invalidation. A load with the probe code looks up one virtual page and returns the cached page table entry word.

The maintenance code sits in address bits [11:8] of the control access. The store data plays no part, so the port has no write-data input. The current context input qualifies probes and every flush scope narrower than the whole cache. A flush and a fill presented in the same cycle are both applied: the flush first, then the fill. Probe misses return zero. This block does not start a table walk.

Top module: `tlb_flush_probe`

## Requirements
- R1: After synchronous reset no line is valid, `ctl_rdata` is zero, and every probe misses.
- R2: Each cycle with `fill_en` high writes one line at the round-robin slot, and the pointer then advances by one, wrapping after ENTRIES fills. The line takes its tag from `fill_va[31:12]`, its level from `fill_level` (0 page, 1 segment, 2 region, 3 treated as page), its context from `fill_ctx` and its word from `fill_pte`.
- R3: A load (`ctl_re` high) whose address has code 4 in bits [11:8] is a probe. In the next cycle `ctl_rdata` holds the word of the lowest-numbered valid line that meets two conditions: its context equals `cur_ctx`, and its tag equals the probe address on bits [31:12] for a page line, bits [31:18] for a segment line, or bits [31:24] for a region line.
- R4: A probe that finds no such line, and a load with any code other than 4, both yield zero on `ctl_rdata` in the next cycle.
- R5: A probe changes neither the valid lines nor the round-robin pointer.
- R6: A store (`ctl_we` high) with code 0 invalidates the lines of the current context that match the store address. The compare uses bits [31:12], or the coarser bits of a segment or region line, so a page flush inside a larger mapping removes that mapping.
- R7: A store with code 1 invalidates current-context lines matching on bits [31:18], or on [31:24] for region lines.
- R8: A store with code 2 invalidates current-context lines matching on bits [31:24].
- R9: A store with code 3 invalidates every line of the current context and keeps lines of other contexts.
- R10: A store with code 4 invalidates every line regardless of context.
- R11: Stores with codes 5 to 15 leave the cache unchanged.
- R12: When the parameter for the segment, region or context scope is cleared, its code is ignored like codes 5 to 15. The whole-cache flush is always present.
- R13: A flush takes one cycle. A fill in the same cycle as a flush is written after the flush, so the filled line stays valid even under a whole-cache flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_addr | input | 32 | Control access address: bits [31:12] virtual page, bits [11:8] maintenance code |
| ctl_we | input | 1 | Control store strobe, starts a flush |
| ctl_re | input | 1 | Control load strobe, starts a probe when the code is 4 |
| ctl_rdata | output | 32 | Probe result, valid the cycle after the load |
| cur_ctx | input | CTX_W | Current context number |
| fill_en | input | 1 | Fill strobe from the table walker |
| fill_va | input | 32 | Virtual address of the filled mapping |
| fill_level | input | 2 | Mapping size of the filled line |
| fill_ctx | input | CTX_W | Context of the filled line |
| fill_pte | input | 32 | Page table entry word to cache |

## Verification
The bench builds two copies from the same stimulus. One copy uses 8 lines, a 16-bit context and all scopes enabled. The other has the segment, region and context scopes turned off, so the same store can be seen to flush in one copy and to do nothing in the other. With only eight lines, a full turn of the replacement pointer takes a few fills. That makes the overwrite of a chosen slot reachable, which in turn shows that probes never move the pointer. The mix of page, segment and region lines in three contexts exercises the coarser-boundary rule from both directions.

// File: rtl/tlbfp_pkg.sv
package tlbfp_pkg;

    localparam int VA_W       = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int SEG_SHIFT  = 18;
    localparam int RGN_SHIFT  = 24;
    localparam int VPN_W      = VA_W - PAGE_SHIFT;
    localparam int SEG_KEEP   = VA_W - SEG_SHIFT;
    localparam int RGN_KEEP   = VA_W - RGN_SHIFT;
    localparam int PTE_W      = 32;
    localparam int CODE_LSB   = 8;
    localparam int CODE_W     = 4;

    localparam logic [CODE_W-1:0] CODE_PAGE  = 4'd0;
    localparam logic [CODE_W-1:0] CODE_SEG   = 4'd1;
    localparam logic [CODE_W-1:0] CODE_RGN   = 4'd2;
    localparam logic [CODE_W-1:0] CODE_CTX   = 4'd3;
    localparam logic [CODE_W-1:0] CODE_ALL   = 4'd4;
    localparam logic [CODE_W-1:0] CODE_PROBE = 4'd4;

    typedef enum logic [1:0] {
        LVL_PAGE = 2'd0,
        LVL_SEG  = 2'd1,
        LVL_RGN  = 2'd2
    } map_lvl_e;

    typedef enum logic [2:0] {
        FL_NONE,
        FL_PAGE,
        FL_SEG,
        FL_RGN,
        FL_CTX,
        FL_ALL
    } flush_kind_e;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        map_lvl_e         lvl;
        logic [PTE_W-1:0] pte;
    } tlb_line_t;

    // Tag bits that take part in a compare at a given mapping size.
    function automatic logic [VPN_W-1:0] vpn_mask(input map_lvl_e l);
        case (l)
            LVL_SEG: vpn_mask = {{SEG_KEEP{1'b1}}, {(VPN_W-SEG_KEEP){1'b0}}};
            LVL_RGN: vpn_mask = {{RGN_KEEP{1'b1}}, {(VPN_W-RGN_KEEP){1'b0}}};
            default: vpn_mask = {VPN_W{1'b1}};
        endcase
    endfunction

    function automatic int lvl_rank(input map_lvl_e l);
        case (l)
            LVL_SEG: lvl_rank = 1;
            LVL_RGN: lvl_rank = 2;
            default: lvl_rank = 0;
        endcase
    endfunction

    // The coarser of two sizes decides how many tag bits are compared.
    function automatic map_lvl_e wider(input map_lvl_e a, input map_lvl_e b);
        wider = (lvl_rank(a) >= lvl_rank(b)) ? a : b;
    endfunction

    function automatic map_lvl_e flush_lvl(input flush_kind_e k);
        case (k)
            FL_SEG:  flush_lvl = LVL_SEG;
            FL_RGN:  flush_lvl = LVL_RGN;
            default: flush_lvl = LVL_PAGE;
        endcase
    endfunction

endpackage

// File: rtl/tlbfp_line_match.sv
module tlbfp_line_match
    import tlbfp_pkg::*;
#(
    parameter int CTX_W = 16
) (
    input  logic                 line_valid,
    input  tlb_line_t            line,
    input  logic [CTX_W-1:0]     line_ctx,
    input  logic [CTX_W-1:0]     cur_ctx,
    input  flush_kind_e          fl_kind,
    input  logic [VPN_W-1:0]     fl_vpn,
    input  logic [VPN_W-1:0]     pr_vpn,
    output logic                 fl_hit,
    output logic                 pr_hit
);

    logic     ctx_eq;
    logic     fl_addr_eq;
    logic     scoped;
    map_lvl_e fl_cmp_lvl;

    always_comb begin
        ctx_eq     = (line_ctx == cur_ctx);
        fl_cmp_lvl = wider(flush_lvl(fl_kind), line.lvl);
        fl_addr_eq = ((line.vpn ^ fl_vpn) & vpn_mask(fl_cmp_lvl)) == '0;
        case (fl_kind)
            FL_PAGE, FL_SEG, FL_RGN: scoped = ctx_eq && fl_addr_eq;
            FL_CTX:                  scoped = ctx_eq;
            FL_ALL:                  scoped = 1'b1;
            default:                 scoped = 1'b0;
        endcase
        fl_hit = line_valid && scoped;
        pr_hit = line_valid && ctx_eq &&
                 (((line.vpn ^ pr_vpn) & vpn_mask(line.lvl)) == '0);
    end

endmodule

// File: rtl/tlbfp_first_hit.sv
module tlbfp_first_hit #(
    parameter int N = 8,
    parameter int W = 32
) (
    input  logic [N-1:0]        hits,
    input  logic [N-1:0][W-1:0] data,
    output logic                any_hit,
    output logic [W-1:0]        sel_data
);

    // Lowest index wins when several lines match.
    always_comb begin
        any_hit  = |hits;
        sel_data = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) sel_data = data[i];
        end
    end

endmodule

// File: rtl/tlbfp_rr_ptr.sv
module tlbfp_rr_ptr #(
    parameter int N = 8,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [PW-1:0] ptr
);

    localparam logic [PW-1:0] LAST = PW'(N - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_flush_probe.sv
module tlb_flush_probe
    import tlbfp_pkg::*;
#(
    parameter int ENTRIES      = 8,
    parameter int CTX_W        = 16,
    parameter bit SEG_FLUSH_EN = 1'b1,
    parameter bit RGN_FLUSH_EN = 1'b1,
    parameter bit CTX_FLUSH_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [31:0]      ctl_addr,
    input  logic             ctl_we,
    input  logic             ctl_re,
    output logic [31:0]      ctl_rdata,
    input  logic [CTX_W-1:0] cur_ctx,
    input  logic             fill_en,
    input  logic [31:0]      fill_va,
    input  logic [1:0]       fill_level,
    input  logic [CTX_W-1:0] fill_ctx,
    input  logic [31:0]      fill_pte
);

    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [CODE_W-1:0]           code;
    logic [VPN_W-1:0]            acc_vpn;
    flush_kind_e                 fl_kind;
    logic                        probe_req;

    tlb_line_t                   lines_q [ENTRIES];
    logic [CTX_W-1:0]            ctx_q   [ENTRIES];
    logic [ENTRIES-1:0]          valid_q;
    logic [ENTRIES-1:0]          valid_next;
    logic [ENTRIES-1:0]          fl_hit;
    logic [ENTRIES-1:0]          pr_hit;
    logic [ENTRIES-1:0][PTE_W-1:0] pte_vec;
    logic                        pr_any;
    logic [PTE_W-1:0]            pr_pte;
    logic [PTR_W-1:0]            ptr;
    logic [31:0]                 rdata_q;

    wire unused_addr_low = ^{ctl_addr[CODE_LSB-1:0], fill_va[PAGE_SHIFT-1:0]};

    assign code    = ctl_addr[CODE_LSB +: CODE_W];
    assign acc_vpn = ctl_addr[VA_W-1:PAGE_SHIFT];

    // Maintenance decode: the scope lives in the address, not the data.
    always_comb begin
        fl_kind = FL_NONE;
        if (ctl_we) begin
            case (code)
                CODE_PAGE: fl_kind = FL_PAGE;
                CODE_SEG:  fl_kind = SEG_FLUSH_EN ? FL_SEG : FL_NONE;
                CODE_RGN:  fl_kind = RGN_FLUSH_EN ? FL_RGN : FL_NONE;
                CODE_CTX:  fl_kind = CTX_FLUSH_EN ? FL_CTX : FL_NONE;
                CODE_ALL:  fl_kind = FL_ALL;
                default:   fl_kind = FL_NONE;
            endcase
        end
    end

    assign probe_req = ctl_re && (code == CODE_PROBE);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_line
        tlbfp_line_match #(.CTX_W(CTX_W)) u_match (
            .line_valid (valid_q[g]),
            .line       (lines_q[g]),
            .line_ctx   (ctx_q[g]),
            .cur_ctx    (cur_ctx),
            .fl_kind    (fl_kind),
            .fl_vpn     (acc_vpn),
            .pr_vpn     (acc_vpn),
            .fl_hit     (fl_hit[g]),
            .pr_hit     (pr_hit[g])
        );
        assign pte_vec[g] = lines_q[g].pte;
    end

    tlbfp_first_hit #(.N(ENTRIES), .W(PTE_W)) u_pick (
        .hits     (pr_hit),
        .data     (pte_vec),
        .any_hit  (pr_any),
        .sel_data (pr_pte)
    );

    tlbfp_rr_ptr #(.N(ENTRIES)) u_rr (
        .clk (clk),
        .rst (rst),
        .adv (fill_en),
        .ptr (ptr)
    );

    // Flush clears first; a same-cycle fill then sets its slot.
    always_comb begin
        valid_next = valid_q & ~fl_hit;
        if (fill_en) valid_next[ptr] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            rdata_q <= '0;
        end else begin
            valid_q <= valid_next;
            rdata_q <= (probe_req && pr_any) ? pr_pte : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            lines_q[ptr] <= '{vpn: fill_va[VA_W-1:PAGE_SHIFT],
                              lvl: map_lvl_e'(fill_level),
                              pte: fill_pte};
            ctx_q[ptr]   <= fill_ctx;
        end
    end

    assign ctl_rdata = rdata_q;

    // R2: a fill leaves a valid line tagged with its address at the old pointer.
    p_fill_lands_r2: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> valid_q[$past(ptr)] &&
                    (lines_q[$past(ptr)].vpn == $past(fill_va[VA_W-1:PAGE_SHIFT])));

    // R4: nonzero read data only follows a probe load.
    p_rdata_only_probe_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl_rdata != '0) |-> $past(ctl_re && (ctl_addr[CODE_LSB +: CODE_W] == CODE_PROBE)));

    // R5: a pure load changes neither line state nor replacement pointer.
    p_probe_keeps_state_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl_re && !ctl_we && !fill_en) |=> $stable(valid_q) && $stable(ptr));

    // R10: whole-cache flush without a fill leaves nothing valid.
    p_whole_flush_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (fl_kind == FL_ALL && !fill_en) |=> (valid_q == '0));

    // R11: unused codes keep the cache as it was.
    p_bad_code_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && (ctl_addr[CODE_LSB +: CODE_W] > CODE_ALL) && !fill_en) |=> $stable(valid_q));

    // R13: a fill under a flush survives it.
    p_fill_over_flush_r13: assert property (@(posedge clk) disable iff (rst)
        (fill_en && ctl_we) |=> valid_q[$past(ptr)]);

endmodule

// File: tb/tlb_flush_probe_tb_top.sv
`timescale 1ns/1ps
module tlb_flush_probe_tb_top;

    localparam int ENTRIES = 8;
    localparam int NV      = 33;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] ctl_addr;
    logic        ctl_we;
    logic        ctl_re;
    logic [31:0] ctl_rdata;
    logic [31:0] rdata_min;
    logic [15:0] cur_ctx;
    logic        fill_en;
    logic [31:0] fill_va;
    logic [1:0]  fill_level;
    logic [15:0] fill_ctx;
    logic [31:0] fill_pte;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    tlb_flush_probe #(.ENTRIES(ENTRIES), .CTX_W(16)) dut_i (
        .clk(clk), .rst(rst), .ctl_addr(ctl_addr), .ctl_we(ctl_we), .ctl_re(ctl_re),
        .ctl_rdata(ctl_rdata), .cur_ctx(cur_ctx), .fill_en(fill_en), .fill_va(fill_va),
        .fill_level(fill_level), .fill_ctx(fill_ctx), .fill_pte(fill_pte)
    );

    tlb_flush_probe #(.ENTRIES(ENTRIES), .CTX_W(16), .SEG_FLUSH_EN(1'b0),
                      .RGN_FLUSH_EN(1'b0), .CTX_FLUSH_EN(1'b0)) dut_min_i (
        .clk(clk), .rst(rst), .ctl_addr(ctl_addr), .ctl_we(ctl_we), .ctl_re(ctl_re),
        .ctl_rdata(rdata_min), .cur_ctx(cur_ctx), .fill_en(fill_en), .fill_va(fill_va),
        .fill_level(fill_level), .fill_ctx(fill_ctx), .fill_pte(fill_pte)
    );

    // {req[84:81], is_load[80], addr[79:48], ctx[47:32], expected[31:0]}
    localparam logic [84:0] VECS [NV] = '{
        // R3 probes at page, segment and region size
        {4'd3, 1'b1, 32'h12345400, 16'h0001, 32'hAAAA0002},
        {4'd3, 1'b1, 32'h12346400, 16'h0001, 32'h00001102},
        {4'd3, 1'b1, 32'h12347400, 16'h0001, 32'h00000000},
        {4'd3, 1'b1, 32'h12417400, 16'h0001, 32'h00002202},
        {4'd3, 1'b1, 32'h55ABC400, 16'h0001, 32'h00003302},
        {4'd3, 1'b1, 32'h55ABC400, 16'h0002, 32'h00000000},
        {4'd3, 1'b1, 32'h12345400, 16'h0002, 32'h00004402},
        // R4 load with a non-probe code
        {4'd4, 1'b1, 32'h12345300, 16'h0001, 32'h00000000},
        // R11 codes 5 and 15
        {4'd11, 1'b0, 32'h12345500, 16'h0001, 32'h00000000},
        {4'd11, 1'b1, 32'h12345400, 16'h0001, 32'hAAAA0002},
        {4'd11, 1'b0, 32'h00000F00, 16'h0001, 32'h00000000},
        {4'd11, 1'b1, 32'h90001400, 16'h0001, 32'h00006602},
        // R6 page flush, then page flush inside a segment line
        {4'd6, 1'b0, 32'h12345000, 16'h0001, 32'h00000000},
        {4'd6, 1'b1, 32'h12345400, 16'h0001, 32'h00000000},
        {4'd6, 1'b1, 32'h12345400, 16'h0002, 32'h00004402},
        {4'd6, 1'b1, 32'h12346400, 16'h0001, 32'h00001102},
        {4'd6, 1'b0, 32'h12410000, 16'h0001, 32'h00000000},
        {4'd6, 1'b1, 32'h12417400, 16'h0001, 32'h00000000},
        // R7 segment flush
        {4'd7, 1'b0, 32'h12340100, 16'h0001, 32'h00000000},
        {4'd7, 1'b1, 32'h12346400, 16'h0001, 32'h00000000},
        {4'd7, 1'b1, 32'h90001400, 16'h0001, 32'h00006602},
        // R8 region flush
        {4'd8, 1'b0, 32'h55FF0200, 16'h0001, 32'h00000000},
        {4'd8, 1'b1, 32'h55ABC400, 16'h0001, 32'h00000000},
        {4'd8, 1'b0, 32'h77000200, 16'h0001, 32'h00000000},
        {4'd8, 1'b1, 32'h77123400, 16'h0002, 32'h00005502},
        // R9 context flush
        {4'd9, 1'b0, 32'h00000300, 16'h0002, 32'h00000000},
        {4'd9, 1'b1, 32'h12345400, 16'h0002, 32'h00000000},
        {4'd9, 1'b1, 32'h77123400, 16'h0002, 32'h00000000},
        {4'd9, 1'b1, 32'h90001400, 16'h0001, 32'h00006602},
        {4'd9, 1'b1, 32'hA0000400, 16'h0003, 32'h00007702},
        // R10 whole flush
        {4'd10, 1'b0, 32'h00000400, 16'h0009, 32'h00000000},
        {4'd10, 1'b1, 32'h90001400, 16'h0001, 32'h00000000},
        {4'd10, 1'b1, 32'hA0000400, 16'h0003, 32'h00000000}
    };

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_fill(input logic [31:0] va, input logic [1:0] lvl,
                           input logic [15:0] ctx, input logic [31:0] pte);
        @(negedge clk);
        fill_en = 1'b1; fill_va = va; fill_level = lvl; fill_ctx = ctx; fill_pte = pte;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic do_store(input logic [31:0] addr, input logic [15:0] ctx);
        @(negedge clk);
        ctl_we = 1'b1; ctl_addr = addr; cur_ctx = ctx;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic do_probe(input logic [31:0] addr, input logic [15:0] ctx,
                            output logic [31:0] got, output logic [31:0] got_min);
        @(negedge clk);
        ctl_re = 1'b1; ctl_addr = addr; cur_ctx = ctx;
        @(negedge clk);
        ctl_re = 1'b0;
        got = ctl_rdata;
        got_min = rdata_min;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] got;
        logic [31:0] gmin;
        rst = 1'b1; ctl_addr = '0; ctl_we = 1'b0; ctl_re = 1'b0; cur_ctx = '0;
        fill_en = 1'b0; fill_va = '0; fill_level = '0; fill_ctx = '0; fill_pte = '0;
        repeat (3) @(negedge clk);
        check(1, ctl_rdata, 32'h0);            // R1 read data cleared
        rst = 1'b0;
        do_probe(32'h00000400, 16'h0000, got, gmin);
        check(1, got, 32'h0);                  // R1 nothing valid

        // Table contents, slots 0..7 in order.
        do_fill(32'h12345000, 2'd0, 16'h0001, 32'hAAAA0002);
        do_fill(32'h12346000, 2'd0, 16'h0001, 32'h00001102);
        do_fill(32'h12400000, 2'd1, 16'h0001, 32'h00002202);
        do_fill(32'h55000000, 2'd2, 16'h0001, 32'h00003302);
        do_fill(32'h12345000, 2'd0, 16'h0002, 32'h00004402);
        do_fill(32'h77000000, 2'd2, 16'h0002, 32'h00005502);
        do_fill(32'h90001000, 2'd0, 16'h0001, 32'h00006602);
        do_fill(32'hA0000000, 2'd0, 16'h0003, 32'h00007702);

        for (int i = 0; i < NV; i++) begin
            logic [84:0] v;
            v = VECS[i];
            if (v[80]) begin
                do_probe(v[79:48], v[47:32], got, gmin);
                check(int'(v[84:81]), got, v[31:0]);
            end else begin
                do_store(v[79:48], v[47:32]);
            end
        end

        // R12 optional scopes disabled in dut_min_i
        do_fill(32'hD0000000, 2'd0, 16'h0005, 32'h000000DD);
        do_store(32'hD0000100, 16'h0005);
        do_probe(32'hD0000400, 16'h0005, got, gmin);
        check(7, got, 32'h0);                  // R7 full copy flushed
        check(12, gmin, 32'h000000DD);         // R12 segment code ignored
        do_store(32'hD0000200, 16'h0005);
        do_store(32'h00000300, 16'h0005);
        do_probe(32'hD0000400, 16'h0005, got, gmin);
        check(12, gmin, 32'h000000DD);         // R12 region and context codes ignored
        do_store(32'h00000400, 16'h0005);
        do_probe(32'hD0000400, 16'h0005, got, gmin);
        check(12, gmin, 32'h0);                // R12 whole flush still present

        // R2 round robin: ENTRIES+1 fills overwrite the first one
        for (int i = 0; i <= ENTRIES; i++) begin
            do_fill(32'(i) << 12, 2'd0, 16'h0004, 32'h100 + 32'(i));
        end
        do_probe(32'h00000400, 16'h0004, got, gmin);
        check(2, got, 32'h0);
        do_probe(32'h00008400, 16'h0004, got, gmin);
        check(2, got, 32'h108);
        do_probe(32'h00001400, 16'h0004, got, gmin);
        check(2, got, 32'h101);

        // R13 whole flush and fill in the same cycle
        @(negedge clk);
        ctl_we = 1'b1; ctl_addr = 32'h00000400; cur_ctx = 16'h0004;
        fill_en = 1'b1; fill_va = 32'hB0000000; fill_level = 2'd0;
        fill_ctx = 16'h0004; fill_pte = 32'h000000BB;
        @(negedge clk);
        ctl_we = 1'b0; fill_en = 1'b0;
        do_probe(32'hB0000400, 16'h0004, got, gmin);
        check(13, got, 32'h000000BB);
        do_probe(32'h00001400, 16'h0004, got, gmin);
        check(13, got, 32'h0);

        // R5 probes must not move the pointer: BB falls only on the ENTRIES-th fill
        do_probe(32'hB0000400, 16'h0004, got, gmin);
        check(5, got, 32'h000000BB);           // repeat probe gives same word
        for (int i = 0; i < ENTRIES - 1; i++) begin
            do_fill(32'hC0000000 + (32'(i) << 12), 2'd0, 16'h0004, 32'h200 + 32'(i));
        end
        do_probe(32'hB0000400, 16'h0004, got, gmin);
        check(5, got, 32'h000000BB);
        do_fill(32'hC0100000, 2'd0, 16'h0004, 32'h000002FF);
        do_probe(32'hB0000400, 16'h0004, got, gmin);
        check(5, got, 32'h0);
        do_probe(32'hC0100400, 16'h0004, got, gmin);
        check(2, got, 32'h000002FF);

        finish_run();
    end

endmodule